// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

The block gathers one-cycle event pulses from four source groups (protocol events, controller-host events, per-receive-buffer status updates and per-transmit-buffer status updates) into latched flags. Each flag stays set until the host clears it by writing a one to its bit. Each flag has its own enable bit. Enabled, pending flags inside a group are ORed and then gated by a group enable to form a group request. The group requests are ORed and gated by a module enable to form the module request.

A separate bank of four reset-cause flags (power-on, low-voltage, clock-monitor, external reset) holds the interrupt pin low until software has cleared every one of them. The active-low pin is driven from a flop and changes one clock after the request that causes it. The host uses a single-cycle write strobe with address and data. Read data for the address presented at a clock edge appears after that edge.

Top module: `irq_aggregator`

## Requirements
- R1: Writing to a flag register (protocol 0x0, controller-host 0x2, receive 0x4, transmit 0x6, reset-cause 0xA) clears exactly the flags whose write-data bits are 1. Flags whose write-data bits are 0 keep their value.
- R2: When a host clear and an event pulse hit the same flag in the same cycle, the flag is set after that cycle.
- R3: An event pulse on an input bit sets the matching flag at the next clock edge. The flag then holds without further pulses.
- R4: Group request bit g (0 protocol, 1 controller-host, 2 receive, 3 transmit) is 1 exactly when some flag of group g and its enable (registers 0x1, 0x3, 0x5, 0x7) are both 1 and bit g of the group control register 0x8 is 1.
- R5: The module request is 1 exactly when at least one group request is 1 and bit 4 of register 0x8 is 1.
- R6: Reading register 0x9 returns the live group requests in bits 3:0, the module request in bit 4, and in bits 5 and 6 whether any receive or transmit buffer flag is set. The read changes no state.
- R7: While any reset-cause flag (register 0xA, bits 3:0 = power-on, low-voltage, clock-monitor, external) is 1, the interrupt pin is driven low one cycle later, whatever the enables.
- R8: The interrupt pin is a registered output. After each edge it equals the inverse of (module request OR any reset-cause flag) as it stood before that edge.
- R9: After reset all flags, enables and group controls are 0, the pin is high, all requests are 0 and read data is 0.
- R10: Read data after an edge is the register selected by the address sampled at that edge, zero-extended. Addresses 0xB to 0xF read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_evt | input | N_PROT | Protocol event pulses |
| chi_evt | input | N_CHI | Controller-host event pulses |
| rxb_upd | input | N_RXB | Receive buffer status-update pulses |
| txb_upd | input | N_TXB | Transmit buffer status-update pulses |
| rcause_evt | input | 4 | Reset-cause event pulses |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Host register address |
| wdata | input | DW | Host write data |
| rdata | output | DW | Registered read data |
| grp_req | output | 4 | Combined group requests |
| mod_req | output | 1 | Combined module request |
| irq_n | output | 1 | Registered active-low level interrupt |

## Verification
The assertions check on every cycle that a pulsed flag is set after the pulse even under a simultaneous clear. They also check that a write with no events clears exactly the written ones, that a group request never appears without its group enable, that the module request needs a group request, and that any reset-cause flag pulls the pin low one cycle later. The bench's scenarios are needed to show the exact values: the per-bit enable gating, the summary read and its lack of side effects, the decoding of the register addresses and the one-cycle pin latency. A long pseudo-random sweep over events, writes and reads compares every output against an arithmetic model on each cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned AW   = 4;
  localparam int unsigned NGRP = 4;
  localparam int unsigned NRC  = 4;

  localparam logic [AW-1:0] A_PROT_FLG = 4'h0;
  localparam logic [AW-1:0] A_PROT_EN  = 4'h1;
  localparam logic [AW-1:0] A_CHI_FLG  = 4'h2;
  localparam logic [AW-1:0] A_CHI_EN   = 4'h3;
  localparam logic [AW-1:0] A_RXB_FLG  = 4'h4;
  localparam logic [AW-1:0] A_RXB_EN   = 4'h5;
  localparam logic [AW-1:0] A_TXB_FLG  = 4'h6;
  localparam logic [AW-1:0] A_TXB_EN   = 4'h7;
  localparam logic [AW-1:0] A_GRP_CTL  = 4'h8;
  localparam logic [AW-1:0] A_SUMMARY  = 4'h9;
  localparam logic [AW-1:0] A_RCAUSE   = 4'hA;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         flg_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wval,
  output logic [W-1:0] flags,
  output logic [W-1:0] en,
  output logic         pend
);
  logic [W-1:0] clr_mask;

  assign clr_mask = flg_wr ? wval : '0;

  // hardware set dominates host clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= (flags & ~clr_mask) | evt;
      if (en_wr) en <= wval;
    end
  end

  assign pend = |(flags & en);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic hold,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(req | hold);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_PROT = 8,
  parameter int unsigned N_CHI  = 4,
  parameter int unsigned N_RXB  = 8,
  parameter int unsigned N_TXB  = 8,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PROT-1:0] prot_evt,
  input  logic [N_CHI-1:0]  chi_evt,
  input  logic [N_RXB-1:0]  rxb_upd,
  input  logic [N_TXB-1:0]  txb_upd,
  input  logic [NRC-1:0]    rcause_evt,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NGRP-1:0]   grp_req,
  output logic              mod_req,
  output logic              irq_n
);
  localparam int unsigned CTLW = NGRP + 1;

  logic [N_PROT-1:0] prot_flags, prot_en;
  logic [N_CHI-1:0]  chi_flags, chi_en;
  logic [N_RXB-1:0]  rxb_flags, rxb_en;
  logic [N_TXB-1:0]  txb_flags, txb_en;
  logic [NGRP-1:0]   grp_pend;
  logic [CTLW-1:0]   grp_ctl;
  logic [NRC-1:0]    rc_flags;
  logic [DW-1:0]     rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input logic [AW-1:0] sel);
    return a == sel;
  endfunction

  irq_flag_bank #(.W(N_PROT)) u_prot (
    .clk(clk), .rst(rst), .evt(prot_evt),
    .flg_wr(wr_en && hit(addr, A_PROT_FLG)), .en_wr(wr_en && hit(addr, A_PROT_EN)),
    .wval(wdata[N_PROT-1:0]), .flags(prot_flags), .en(prot_en), .pend(grp_pend[0]));

  irq_flag_bank #(.W(N_CHI)) u_chi (
    .clk(clk), .rst(rst), .evt(chi_evt),
    .flg_wr(wr_en && hit(addr, A_CHI_FLG)), .en_wr(wr_en && hit(addr, A_CHI_EN)),
    .wval(wdata[N_CHI-1:0]), .flags(chi_flags), .en(chi_en), .pend(grp_pend[1]));

  irq_flag_bank #(.W(N_RXB)) u_rxb (
    .clk(clk), .rst(rst), .evt(rxb_upd),
    .flg_wr(wr_en && hit(addr, A_RXB_FLG)), .en_wr(wr_en && hit(addr, A_RXB_EN)),
    .wval(wdata[N_RXB-1:0]), .flags(rxb_flags), .en(rxb_en), .pend(grp_pend[2]));

  irq_flag_bank #(.W(N_TXB)) u_txb (
    .clk(clk), .rst(rst), .evt(txb_upd),
    .flg_wr(wr_en && hit(addr, A_TXB_FLG)), .en_wr(wr_en && hit(addr, A_TXB_EN)),
    .wval(wdata[N_TXB-1:0]), .flags(txb_flags), .en(txb_en), .pend(grp_pend[3]));

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_ctl  <= '0;
      rc_flags <= '0;
    end else begin
      if (wr_en && hit(addr, A_GRP_CTL)) grp_ctl <= wdata[CTLW-1:0];
      rc_flags <= (rc_flags & ~((wr_en && hit(addr, A_RCAUSE)) ? wdata[NRC-1:0] : '0))
                | rcause_evt;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_gate
      assign grp_req[g] = grp_pend[g] & grp_ctl[g];
    end
  endgenerate

  assign mod_req = (|grp_req) & grp_ctl[NGRP];

  irq_pin_drv u_pin (
    .clk(clk), .rst(rst), .req(mod_req), .hold(|rc_flags), .irq_n(irq_n));

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PROT_FLG: rd_mux[N_PROT-1:0] = prot_flags;
      A_PROT_EN:  rd_mux[N_PROT-1:0] = prot_en;
      A_CHI_FLG:  rd_mux[N_CHI-1:0]  = chi_flags;
      A_CHI_EN:   rd_mux[N_CHI-1:0]  = chi_en;
      A_RXB_FLG:  rd_mux[N_RXB-1:0]  = rxb_flags;
      A_RXB_EN:   rd_mux[N_RXB-1:0]  = rxb_en;
      A_TXB_FLG:  rd_mux[N_TXB-1:0]  = txb_flags;
      A_TXB_EN:   rd_mux[N_TXB-1:0]  = txb_en;
      A_GRP_CTL:  rd_mux[CTLW-1:0]   = grp_ctl;
      A_SUMMARY: begin
        rd_mux[NGRP-1:0] = grp_req;
        rd_mux[NGRP]     = mod_req;
        rd_mux[NGRP+1]   = |rxb_flags;
        rd_mux[NGRP+2]   = |txb_flags;
      end
      A_RCAUSE:   rd_mux[NRC-1:0]    = rc_flags;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_PROT = 8,
  parameter int unsigned DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [N_PROT-1:0] prot_evt,
  input logic [N_PROT-1:0] prot_flags,
  input logic [NRC-1:0]    rc_flags,
  input logic [NGRP:0]     grp_ctl,
  input logic [NGRP-1:0]   grp_req,
  input logic              mod_req,
  input logic              irq_n
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|prot_evt) |=> ((prot_flags & $past(prot_evt)) == $past(prot_evt))); // R2

  AST_W1C_EXACT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PROT_FLG && prot_evt == '0)
      |=> (prot_flags == ($past(prot_flags) & ~$past(wdata[N_PROT-1:0])))); // R1

  AST_GRP_GATED: assert property (@(posedge clk) disable iff (rst)
    (grp_req != '0) |-> ((grp_req & ~grp_ctl[NGRP-1:0]) == '0)); // R4

  AST_MOD_NEEDS_GRP: assert property (@(posedge clk) disable iff (rst)
    mod_req |-> (grp_req != '0)); // R5

  AST_RC_HOLDS_PIN: assert property (@(posedge clk) disable iff (rst)
    (rc_flags != '0) |=> !irq_n); // R7

  AST_POST_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grp_req == '0 && !mod_req && irq_n)); // R9
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_PROT(N_PROT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .prot_evt(prot_evt), .prot_flags(prot_flags), .rc_flags(rc_flags),
  .grp_ctl(grp_ctl), .grp_req(grp_req), .mod_req(mod_req), .irq_n(irq_n));

// File: tb/irq_aggregator_test.sv
`timescale 1ns/100ps
module irq_aggregator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] prot_evt = '0;
  logic [3:0] chi_evt = '0;
  logic [7:0] rxb_upd = '0;
  logic [7:0] txb_upd = '0;
  logic [3:0] rcause_evt = '0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] grp_req;
  logic       mod_req;
  logic       irq_n;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .prot_evt(prot_evt), .chi_evt(chi_evt),
    .rxb_upd(rxb_upd), .txb_upd(txb_upd), .rcause_evt(rcause_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .grp_req(grp_req), .mod_req(mod_req), .irq_n(irq_n));

  // reference state: index 0 prot, 1 chi, 2 rx, 3 tx
  logic [7:0] mf [4];
  logic [7:0] me [4];
  logic [4:0] mgc;
  logic [3:0] mrc;
  logic [7:0] exp_rd;
  logic       exp_irq;
  logic [7:0] gmask [4];

  function automatic logic [3:0] m_grp();
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = (|(mf[g] & me[g])) & mgc[g];
    return r;
  endfunction

  function automatic logic m_mod();
    return (|m_grp()) & mgc[4];
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h0, 4'h2, 4'h4, 4'h6: return mf[a[3:1]];
      4'h1, 4'h3, 4'h5, 4'h7: return me[a[3:1]];
      4'h8: return {3'b0, mgc};
      4'h9: return {1'b0, |mf[3], |mf[2], m_mod(), m_grp()};
      4'hA: return {4'b0, mrc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int g = 0; g < 4; g++) begin mf[g] = '0; me[g] = '0; end
    mgc = '0; mrc = '0; exp_rd = '0; exp_irq = 1'b1;
  endtask

  task automatic apply(input logic [7:0] pe, input logic [3:0] ce,
                       input logic [7:0] re, input logic [7:0] te,
                       input logic [3:0] rce, input logic we,
                       input logic [3:0] a, input logic [7:0] d, input string rtag);
    logic [7:0] ev [4];
    @(negedge clk);
    prot_evt = pe; chi_evt = ce; rxb_upd = re; txb_upd = te;
    rcause_evt = rce; wr_en = we; addr = a; wdata = d;
    ev[0] = pe; ev[1] = {4'b0, ce}; ev[2] = re; ev[3] = te;
    @(posedge clk);
    exp_irq = ~(m_mod() | (|mrc));
    exp_rd  = m_read(a);
    for (int g = 0; g < 4; g++) begin
      mf[g] = ((mf[g] & ~((we && a == 4'(2*g)) ? d : 8'h00)) | ev[g]) & gmask[g];
      if (we && a == 4'(2*g+1)) me[g] = d & gmask[g];
    end
    if (we && a == 4'h8) mgc = d[4:0];
    mrc = (mrc & ~((we && a == 4'hA) ? d[3:0] : 4'h0)) | rce;
    #1;
    chk8({4'b0, grp_req}, {4'b0, m_grp()}, "R4 group request");
    chk8({7'b0, mod_req}, {7'b0, m_mod()}, "R5 module request");
    chk8({7'b0, irq_n}, {7'b0, exp_irq}, (mrc != 0) ? "R7 pin hold" : "R8 pin");
    chk8(rdata, exp_rd, rtag);
    prot_evt = '0; chi_evt = '0; rxb_upd = '0; txb_upd = '0;
    rcause_evt = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    apply(8'h0, 4'h0, 8'h0, 8'h0, 4'h0, 1'b0, a, 8'h0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    apply(8'h0, 4'h0, 8'h0, 8'h0, 4'h0, 1'b1, a, d, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R9: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    gmask[0] = 8'hFF; gmask[1] = 8'h0F; gmask[2] = 8'hFF; gmask[3] = 8'hFF;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    // R9 reset state at the ports
    chk8({4'b0, grp_req}, 8'h00, "R9 grp_req after reset");
    chk8({7'b0, mod_req}, 8'h00, "R9 mod_req after reset");
    chk8({7'b0, irq_n}, 8'h01, "R9 irq_n after reset");
    chk8(rdata, 8'h00, "R9 rdata after reset");
    for (int a = 0; a < 16; a++) rd(4'(a), "R9 register reads zero");

    // R3 pulse sets and holds
    apply(8'h04, 4'h0, 8'h00, 8'h80, 4'h0, 1'b0, 4'h0, 8'h0, "R3 read during pulse");
    rd(4'h0, "R3 prot flag held");
    rd(4'h6, "R3 tx flag held");
    rd(4'h9, "R6 summary tx any");
    // R1 write 0 keeps, write 1 clears
    apply(8'h11, 4'h0, 8'h00, 8'h00, 4'h0, 1'b0, 4'h0, 8'h0, "R3 more flags");
    wr(4'h0, 8'h00, "R1 write zero");
    rd(4'h0, "R1 flags unchanged");
    wr(4'h0, 8'h05, "R1 write ones");
    rd(4'h0, "R1 only written bits cleared");
    // R2 set wins over clear
    apply(8'h10, 4'h0, 8'h00, 8'h00, 4'h0, 1'b1, 4'h0, 8'h10, "R2 collide");
    rd(4'h0, "R2 flag remains set");
    // R4/R5 enable hierarchy
    wr(4'h1, 8'h10, "R4 flag enable");
    wr(4'h8, 8'h01, "R4 group enable");
    rd(4'h9, "R6 summary with group");
    wr(4'h8, 8'h11, "R5 module enable");
    rd(4'h9, "R6 summary with module");
    rd(4'h9, "R6 summary read no side effect");
    wr(4'h1, 8'h00, "R4 flag enable off");
    // R7 reset cause holds pin
    apply(8'h00, 4'h0, 8'h00, 8'h00, 4'h6, 1'b0, 4'hA, 8'h0, "R7 rcause pulse");
    rd(4'hA, "R7 rcause flags");
    wr(4'hA, 8'h02, "R7 partial clear");
    rd(4'hA, "R7 one cause left");
    wr(4'hA, 8'h0F, "R7 clear all");
    rd(4'hA, "R7 causes clear");
    // R10 unmapped address ignores writes
    wr(4'hC, 8'hFF, "R10 unmapped write");
    rd(4'hC, "R10 unmapped read");

    // pseudo-random sweep
    s = 32'h1234_5678;
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] t;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      t = s * 32'h9E37_79B9;
      apply(s[7:0] & s[15:8] & s[23:16], t[3:0] & t[7:4], t[15:8] & s[31:24],
            t[23:16] & s[7:0], (t[27:24] & s[11:8] & t[31:28] & 4'(i[3:0] == 0)),
            s[24] | s[25], 4'((s[31:26] ^ t[5:0]) % 12),
            ((s[31:26] % 2) == 1) ? 8'hFF : (t[7:0] ^ s[19:12]),
            (((s[31:26] ^ t[5:0]) % 12) == 9) ? "R6 sweep summary" : "R10 sweep read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule